// File: doc/BRIEF.md
# Adapter Control and Sticky Status Register

This block is a single memory-mapped control and status word for a JTAG debug adapter. Software writes to one bus offset to turn bits on and to a second offset to turn them off. Neither offset needs a read-modify-write, so no read is needed before changing one bit. The control bits drive the pull-down enables of the target system-reset and TAP-reset lines, the target power switch, two indicator LEDs, and the choice between return-clock (adaptive) mode and fixed-divider mode for the JTAG clock.

Three sticky flags share the same word. One records that the target system-reset line was seen asserted, one records a target power dropout, and one records a return-clock timeout. The two sense inputs come from the board, so each passes through a synchronizer before it is latched. The timeout pulse comes from logic in the same clock domain. The two sense flags are re-armed through the set offset, and the timeout flag is re-armed through the clear offset. Reading the set offset returns the control bits and the flags together in one word.

Top module: `adc_csr`

## Requirements
- R1: While reset is held and after it is released, every control output is 0, every flag is 0, and a read of the register returns 0.
- R2: A write to offset 0x10 sets each control bit that is 1 in the written word. The control bits are positions 0, 1, 3, 4, 5 and 8. Bits that are 0 in the word keep their value.
- R3: A write to offset 0x14 clears each control bit that is 1 in the written word. Bits that are 0 in the word keep their value.
- R4: The control outputs are registered copies of the control bits. Bit 0 is `sysrst_pull_o` and bit 1 is `taprst_pull_o`; a 1 on either enables the pull-down of that line. Bit 3 is `tgt_pwr_en_o`. Bits 4 and 5 are `led_o[0]` and `led_o[1]`. Bit 8 is `adapt_clk_en_o`, where 1 selects return-clock mode and 0 selects divider mode.
- R5: A read of offset 0x10 returns, on the clock edge after the address is presented, the control bits at their positions and the flags at bits 6, 7 and 10. Every other bit reads 0. Any other read address returns 0.
- R6: Bit 6 is set once `sysrst_sense_i` has been high through a two-flop synchronizer. It stays set after the line falls. Writing a 1 in bit 6 to offset 0x10 clears it.
- R7: Bit 7 is set once `pwr_drop_i` has been high through a two-flop synchronizer. It stays set after the input falls. Writing a 1 in bit 7 to offset 0x10 clears it.
- R8: Bit 10 is set by a one-cycle high on `rclk_tmo_i` and stays set. Writing a 1 in bit 10 to offset 0x14 clears it.
- R9: If a flag's event is present in the same cycle as a write that would clear that flag, the flag ends up set.
- R10: Writes have no effect in the following cases, and the register keeps its value: bits 6 and 7 written to offset 0x14, bit 10 written to offset 0x10, set writes to the flag positions or reserved positions, and writes to any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sysrst_sense_i | input | 1 | Asynchronous target system-reset sense, high when asserted |
| pwr_drop_i | input | 1 | Asynchronous target power dropout indication |
| rclk_tmo_i | input | 1 | Synchronous return-clock timeout pulse |
| sysrst_pull_o | output | 1 | Pull-down enable for the target system-reset line |
| taprst_pull_o | output | 1 | Pull-down enable for the TAP reset line |
| tgt_pwr_en_o | output | 1 | Target power switch enable |
| led_o | output | 2 | Indicator LED drives |
| adapt_clk_en_o | output | 1 | 1 selects return-clock mode, 0 selects divider mode |

## Verification
Two functions can meet in the same cycle: a flag event, and the bus write that re-arms that flag. The bench provokes this in two ways. For the reset-sense flag, it holds the sense input high through the set-offset write, so the synchronized event coincides with the clear. For the timeout flag, it drives the timeout pulse on the same clock edge as the clear-offset write. In both cases the following read must still show the flag set. The flag must then clear once the event is gone and the write is repeated.

// File: rtl/adc_pkg.sv
package adc_pkg;
  // Number of control bits and sticky flags held in the word
  localparam int unsigned N_CTRL = 6;
  localparam int unsigned N_FLAG = 3;

  // Flag indices inside the flag vector
  localparam int unsigned FL_SENSE = 0;
  localparam int unsigned FL_DROP  = 1;
  localparam int unsigned FL_TMO   = 2;

  // Bit position of control index i within the register word
  function automatic int unsigned ctrl_pos(int unsigned i);
    case (i)
      0: return 0;   // system-reset pull
      1: return 1;   // TAP reset pull
      2: return 3;   // target power
      3: return 4;   // LED 0
      4: return 5;   // LED 1
      default: return 8; // adaptive clock select
    endcase
  endfunction

  // Bit position of flag index i within the register word
  function automatic int unsigned flag_pos(int unsigned i);
    case (i)
      0: return 6;
      1: return 7;
      default: return 10;
    endcase
  endfunction

  // 1 when the flag is re-armed through the set offset, 0 for the clear offset
  function automatic bit flag_clr_on_set(int unsigned i);
    return (i != FL_TMO);
  endfunction
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_sticky.sv
module adc_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flag_o[g] <= 1'b0;
      else if (event_i[g]) flag_o[g] <= 1'b1;   // event wins over clear
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_ctrl_bits.sv
module adc_ctrl_bits #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/adc_csr.sv
module adc_csr #(
  parameter int unsigned        ADDR_W      = 8,
  parameter int unsigned        DATA_W      = 32,
  parameter logic [ADDR_W-1:0]  SET_OFS     = 'h10,
  parameter logic [ADDR_W-1:0]  CLR_OFS     = 'h14,
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sysrst_sense_i,
  input  logic              pwr_drop_i,
  input  logic              rclk_tmo_i,
  output logic              sysrst_pull_o,
  output logic              taprst_pull_o,
  output logic              tgt_pwr_en_o,
  output logic [1:0]        led_o,
  output logic              adapt_clk_en_o
);
  import adc_pkg::*;

  logic                 wr_set, wr_clr;
  logic [N_CTRL-1:0]    ctrl_set, ctrl_clr, ctrl_q;
  logic [N_FLAG-1:0]    flag_evt, flag_clr, flags_q;
  logic [1:0]           sense_sync;
  logic [DATA_W-1:0]    word;
  logic                 unused_wdata;

  assign wr_set = bus_we && (bus_addr == SET_OFS);
  assign wr_clr = bus_we && (bus_addr == CLR_OFS);
  assign unused_wdata = ^bus_wdata;

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl_dec
    assign ctrl_set[c] = wr_set & bus_wdata[ctrl_pos(c)];
    assign ctrl_clr[c] = wr_clr & bus_wdata[ctrl_pos(c)];
  end

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag_dec
    if (flag_clr_on_set(f)) begin : g_by_set
      assign flag_clr[f] = wr_set & bus_wdata[flag_pos(f)];
    end else begin : g_by_clr
      assign flag_clr[f] = wr_clr & bus_wdata[flag_pos(f)];
    end
  end

  adc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({pwr_drop_i, sysrst_sense_i}),
    .q_o (sense_sync)
  );

  assign flag_evt[FL_SENSE] = sense_sync[0];
  assign flag_evt[FL_DROP]  = sense_sync[1];
  assign flag_evt[FL_TMO]   = rclk_tmo_i;

  adc_ctrl_bits #(.N(N_CTRL)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .set_i (ctrl_set),
    .clr_i (ctrl_clr),
    .q_o   (ctrl_q)
  );

  adc_sticky #(.N(N_FLAG)) u_sticky (
    .clk     (clk),
    .rst     (rst),
    .event_i (flag_evt),
    .clr_i   (flag_clr),
    .flag_o  (flags_q)
  );

  always_comb begin
    word = '0;
    for (int c = 0; c < N_CTRL; c++) word[ctrl_pos(c)] = ctrl_q[c];
    for (int f = 0; f < N_FLAG; f++) word[flag_pos(f)] = flags_q[f];
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_addr == SET_OFS) bus_rdata <= word;
    else                         bus_rdata <= '0;
  end

  assign sysrst_pull_o  = ctrl_q[0];
  assign taprst_pull_o  = ctrl_q[1];
  assign tgt_pwr_en_o   = ctrl_q[2];
  assign led_o          = ctrl_q[4:3];
  assign adapt_clk_en_o = ctrl_q[5];
endmodule

// File: rtl/adc_csr_chk.sv
module adc_csr_chk #(
  parameter int unsigned       ADDR_W  = 8,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 'h10,
  parameter logic [ADDR_W-1:0] CLR_OFS = 'h14
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rclk_tmo_i,
  input logic              sysrst_pull_o,
  input logic              tgt_pwr_en_o,
  input logic [2:0]        flags_q
);
  logic w_set, w_clr, w_other;
  assign w_set   = bus_we && (bus_addr == SET_OFS);
  assign w_clr   = bus_we && (bus_addr == CLR_OFS);
  assign w_other = bus_we && (bus_addr != SET_OFS) && (bus_addr != CLR_OFS);

  a_r2_set_sysrst: assert property (@(posedge clk) disable iff (rst)
    (w_set && bus_wdata[0]) |=> sysrst_pull_o);

  a_r3_clr_power: assert property (@(posedge clk) disable iff (rst)
    (w_clr && bus_wdata[3]) |=> !tgt_pwr_en_o);

  a_r10_other_addr: assert property (@(posedge clk) disable iff (rst)
    w_other |=> ($stable(tgt_pwr_en_o) && $stable(sysrst_pull_o)));

  a_r9_tmo_wins: assert property (@(posedge clk) disable iff (rst)
    rclk_tmo_i |=> flags_q[2]);

  a_r8_tmo_hold: assert property (@(posedge clk) disable iff (rst)
    (flags_q[2] && !(w_clr && bus_wdata[10])) |=> flags_q[2]);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (bus_rdata[2] == 1'b0 && bus_rdata[9] == 1'b0));
endmodule

bind adc_csr adc_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rclk_tmo_i(rclk_tmo_i),
  .sysrst_pull_o(sysrst_pull_o), .tgt_pwr_en_o(tgt_pwr_en_o), .flags_q(flags_q)
);

// File: tb/adc_csr_tb.sv
`timescale 1ns/1ps
module adc_csr_tb;
  localparam logic [7:0] SET = 8'h10;
  localparam logic [7:0] CLR = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sense = 1'b0, drop = 1'b0, tmo = 1'b0;
  logic        sysrst_pull, taprst_pull, pwr_en, adapt;
  logic [1:0]  led;
  int          total = 0, bad = 0;
  int          cycles = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  adc_csr u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sysrst_sense_i(sense), .pwr_drop_i(drop), .rclk_tmo_i(tmo),
    .sysrst_pull_o(sysrst_pull), .taprst_pull_o(taprst_pull),
    .tgt_pwr_en_o(pwr_en), .led_o(led), .adapt_clk_en_o(adapt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {26'd0, adapt, led, pwr_en, taprst_pull, sysrst_pull};
  endfunction

  task automatic t_reset();
    check("R1 outputs after reset", outs(), 32'h0);
    rd(SET, rv); check("R1 read after reset", rv, 32'h0);
  endtask

  task automatic t_set();
    wr(SET, 32'h19);
    // adapt,led1,led0,pwr,tap,sys = 0,0,1,1,0,1
    check("R4 output mapping", outs(), 32'h0D);
    rd(SET, rv); check("R2 set bits 0,3,4", rv, 32'h19);
    wr(SET, 32'h122);
    rd(SET, rv); check("R2 set accumulates", rv, 32'h13B);
    check("R4 all controls on", outs(), 32'h3F);
  endtask

  task automatic t_clear();
    wr(CLR, 32'h009);
    rd(SET, rv); check("R3 clear bits 0,3", rv, 32'h132);
    check("R4 outputs after clear", outs(), 32'h3A);
  endtask

  task automatic t_ignore();
    wr(SET, 32'hFFFF_FFFF);
    rd(SET, rv); check("R10 set of flags/reserved ignored", rv, 32'h13B);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(SET, rv); check("R10 other address write ignored", rv, 32'h13B);
    rd(CLR, rv); check("R5 read of other address", rv, 32'h0);
    wr(CLR, 32'hFFFF_FFFF);
    rd(SET, rv); check("R3 clear all", rv, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R10 outputs after stray write", outs(), 32'h0);
  endtask

  task automatic t_sense();
    sense = 1'b1; idle(4);
    rd(SET, rv); check("R6 sense flag set", rv, 32'h40);
    wr(SET, 32'h40);
    rd(SET, rv); check("R9 sense event beats re-arm", rv, 32'h40);
    sense = 1'b0; idle(4);
    rd(SET, rv); check("R6 sense flag sticky", rv, 32'h40);
    wr(CLR, 32'h40);
    rd(SET, rv); check("R10 clear offset leaves sense flag", rv, 32'h40);
    wr(SET, 32'h40);
    rd(SET, rv); check("R6 sense flag re-armed", rv, 32'h0);
  endtask

  task automatic t_drop();
    drop = 1'b1; idle(4); drop = 1'b0; idle(4);
    rd(SET, rv); check("R7 dropout flag sticky", rv, 32'h80);
    wr(CLR, 32'h80);
    rd(SET, rv); check("R10 clear offset leaves dropout flag", rv, 32'h80);
    wr(SET, 32'h80);
    rd(SET, rv); check("R7 dropout flag re-armed", rv, 32'h0);
  endtask

  task automatic t_tmo();
    tmo = 1'b1; @(posedge clk); @(negedge clk); tmo = 1'b0;
    rd(SET, rv); check("R8 timeout flag set", rv, 32'h400);
    wr(SET, 32'h400);
    rd(SET, rv); check("R10 set offset leaves timeout flag", rv, 32'h400);
    wr(CLR, 32'h400);
    rd(SET, rv); check("R8 timeout flag cleared", rv, 32'h0);
    tmo = 1'b1; bus_addr = CLR; bus_wdata = 32'h400; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    tmo = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    rd(SET, rv); check("R9 timeout event beats clear", rv, 32'h400);
    wr(CLR, 32'h400);
    rd(SET, rv); check("R8 timeout cleared again", rv, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(4);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_set();
    t_clear();
    t_ignore();
    t_sense();
    t_drop();
    t_tmo();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule